// File: doc/BRIEF.md
# Processor Tick Timer

This block keeps time for an operating system. A 32-bit counter advances on the processor clock. A control register holds four things: a 28-bit match period, an interrupt enable, a sticky pending flag and a two-bit operating mode. When the low 28 bits of the counter equal the period, a match is recorded. Depending on the mode, the counter then clears, stops or keeps running.

Software reads and writes both registers through a plain single-cycle register port. A select line picks the register: 0 is the counter and 1 is the control register. The interrupt request is raised while a match is pending and the enable bit is set. The scheduler uses it as its periodic tick.

Control register layout: bits [27:0] period, bit 28 pending, bit 29 interrupt enable, bits [31:30] mode (00 off, 01 restart, 10 single-run, 11 continuous).

Top module: `tick_timer`

## Requirements
- R1: After reset, both registers read zero and `irq` is low.
- R2: A write to the counter (select 0) shows in the next cycle. It overrides any increment or clear in that cycle.
- R3: In mode 00 the counter holds its value and no match is recorded.
- R4: A match is counter bits [27:0] equal to the period field (control bits [27:0]). Counter bits [31:28] do not take part.
- R5: In mode 01, a match clears the counter to zero on the next edge, and counting resumes from there. The counter therefore cycles through period+1 values.
- R6: In mode 10, a match freezes the counter at its value and changes the mode field to 00.
- R7: In mode 11 the counter increments every cycle through a match and wraps from all ones to zero.
- R8: A match sets the pending flag (control bit 28) whatever the enable bit is. If the match falls in the same cycle as a write of 0 to that bit, the flag still ends up set.
- R9: Writing the control register loads the pending flag from bit 28 of the write data. Writing 0 clears the flag, and the flag stays set until software clears it.
- R10: `irq` is high exactly when the pending flag and the enable bit (control bit 29) are both set.
- R11: `rd_data` returns the counter when `rd_sel` is 0 and the control register when `rd_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 counter, 1 control |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 counter, 1 control |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Timer interrupt request |

## Verification
Each of the three running modes is swept over periods 0 to 5, once with the interrupt enabled and once with it masked. Every cycle after the mode write, the counter, pending flag, mode field and `irq` are compared against values worked out with modular arithmetic. These sweeps separate a clear-on-match from a stop-on-match from a run-through. They also catch off-by-one errors in the match period, because period 0 and period 5 give very different cycle lengths. A start value with the upper counter bits set, together with an all-ones period, checks that only the low 28 bits are compared and that the counter wraps. Directed sequences cover the remaining corners: a counter write that collides with an increment, and a pending clear that lands on a match cycle.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int PER_W = 28,
  parameter int DW    = PER_W + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam int PEND_B = PER_W;
  localparam int IE_B   = PER_W + 1;
  localparam int MODE_L = PER_W + 2;
  localparam logic [1:0] M_OFF = 2'b00, M_RST = 2'b01, M_ONE = 2'b10, M_RUN = 2'b11;

  logic [DW-1:0]    count;
  logic [PER_W-1:0] period;
  logic             pend, ie;
  logic [1:0]       mode;

  wire wr_cnt = wr_en & ~wr_sel;
  wire wr_ctl = wr_en & wr_sel;
  wire match  = (mode != M_OFF) && (count[PER_W-1:0] == period);

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (wr_cnt) count <= wr_data;
    else begin
      case (mode)
        M_OFF:   count <= count;
        M_RST:   count <= match ? '0 : count + 1'b1;
        M_ONE:   count <= match ? count : count + 1'b1;
        default: count <= count + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period <= '0; pend <= 1'b0; ie <= 1'b0; mode <= M_OFF;
    end else if (wr_ctl) begin
      period <= wr_data[PER_W-1:0];
      pend   <= wr_data[PEND_B] | match;
      ie     <= wr_data[IE_B];
      mode   <= wr_data[MODE_L +: 2];
    end else begin
      pend <= pend | match;
      if (mode == M_ONE && match) mode <= M_OFF;
    end
  end

  assign rd_data = rd_sel ? {mode, ie, pend, period} : count;
  assign irq     = pend & ie;

  assert_count_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> count == $past(wr_data));
  assert_off_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OFF && !wr_cnt) |=> $stable(count));
  assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RST && match && !wr_cnt) |=> count == '0);
  assert_single_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ONE && match && !wr_en) |=> (mode == M_OFF && $stable(count)));
  assert_run_increments_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RUN && !wr_cnt) |=> count == $past(count) + 1'b1);
  assert_pending_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !wr_ctl) |=> pend);
  assert_match_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> pend);
endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic        irq;
  int nchk = 0, nfail = 0, cyc = 0;

  tick_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
                 .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nfail = nfail + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  function automatic logic [31:0] ctl(input logic [1:0] m, input logic e, input logic p, input logic [27:0] per);
    return {m, e, p, per};
  endfunction

  initial begin
    logic [31:0] v, c;
    logic        ep;
    @(negedge clk); @(negedge clk);
    rd(0, v); chk("R1 count under reset", v, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, v); chk("R1 count after reset", v, 0);
    rd(1, v); chk("R1 control after reset", v, 0);
    chk("R1 irq after reset", {31'b0, irq}, 0);

    for (int m = 1; m <= 3; m++)
      for (int e = 0; e <= 1; e++)
        for (int p = 0; p <= 5; p++) begin
          wr(1, 0); wr(0, 0);
          wr(1, ctl(m[1:0], e[0], 1'b0, p[27:0]));
          for (int k = 1; k <= 2*p + 3; k++) begin
            @(negedge clk);
            ep = (k >= p + 1);
            rd(0, v);
            if (m == 1)      chk("R5 restart count", v, k % (p + 1));
            else if (m == 2) chk("R6 single-run count", v, (k < p) ? k : p);
            else             chk("R7 continuous count", v, k);
            rd(1, c);
            chk("R8 pending flag", {31'b0, c[28]}, {31'b0, ep});
            if (m == 2) chk("R6 mode after stop", {30'b0, c[31:30]}, ep ? 0 : 2);
            else        chk("R11 mode readback", {30'b0, c[31:30]}, m);
            chk("R10 irq", {31'b0, irq}, {31'b0, ep & e[0]});
          end
        end

    wr(1, 0); wr(0, 32'h1234_5678);
    wr(1, ctl(2'b00, 1'b1, 1'b0, 28'h234_567A));
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      rd(0, v); chk("R3 off holds count", v, 32'h1234_5678);
      chk("R3 off no irq", {31'b0, irq}, 0);
    end

    wr(1, 0); wr(0, 32'hFFFF_FFFE);
    wr(1, ctl(2'b11, 1'b1, 1'b0, 28'hFFF_FFFF));
    @(negedge clk); rd(0, v); chk("R7 near wrap", v, 32'hFFFF_FFFF);
    chk("R4 no early match", {31'b0, irq}, 0);
    @(negedge clk); rd(0, v); chk("R7 wraps to zero", v, 0);
    chk("R4 low bits match with upper set", {31'b0, irq}, 1);

    wr(1, 0); wr(0, 32'h3000_0000);
    wr(1, ctl(2'b11, 1'b0, 1'b0, 28'd3));
    for (int k = 1; k <= 5; k++) @(negedge clk);
    rd(1, c); chk("R4 match ignores top bits", {31'b0, c[28]}, 1);
    chk("R10 masked pending no irq", {31'b0, irq}, 0);
    rd(0, v); chk("R7 count kept running", v, 32'h3000_0005);
    wr(0, 32'd100);
    rd(0, v); chk("R2 write beats increment", v, 100);
    @(negedge clk); rd(0, v); chk("R2 count resumes", v, 101);
    wr(1, ctl(2'b00, 1'b1, 1'b1, 28'd3));
    chk("R10 enable with pending", {31'b0, irq}, 1);
    wr(1, ctl(2'b00, 1'b1, 1'b0, 28'd3));
    chk("R9 clear pending drops irq", {31'b0, irq}, 0);

    wr(0, 0); wr(1, ctl(2'b01, 1'b1, 1'b0, 28'd3));
    for (int k = 1; k <= 3; k++) @(negedge clk);
    rd(0, v); chk("R5 at match value", v, 3);
    wr(1, ctl(2'b01, 1'b1, 1'b0, 28'd3));
    rd(1, c); chk("R8 set wins over clear", {31'b0, c[28]}, 1);
    rd(0, v); chk("R5 cleared on match", v, 0);
    wr(1, ctl(2'b01, 1'b1, 1'b0, 28'd3));
    rd(1, c); chk("R9 clear away from match", {31'b0, c[28]}, 0);

    wr(1, ctl(2'b00, 1'b0, 1'b0, 28'd3)); wr(0, 32'd1);
    wr(1, ctl(2'b11, 1'b0, 1'b0, 28'd3));
    wr(0, 32'd3);
    rd(0, v); chk("R2 write during run", v, 3);
    @(negedge clk);
    rd(1, c); chk("R8 match from written count", {31'b0, c[28]}, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule